// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This unit watches the live calendar counters of a real-time clock and raises an alarm when they reach a programmed point in time. Software programs four alarm bytes: minute, hour, day of month and weekday. Each byte carries a disable bit in bit 7, so any field can be left out of the comparison. On every time-update strobe the unit compares the enabled fields with the current BCD time. The first time all enabled fields agree, a sticky alarm flag is set. That flag stays set until software clears it. It can be set again only after the time has first left the matching state and then entered it again.

Software reaches the unit through a byte-wide register port with a write strobe, an address and a combinational read path. The control byte holds the alarm interrupt enable and the alarm flag. The flag bit is write-to-clear: the written value is ANDed with the flag, so a read-modify-write that returns a 1 never disturbs it. The interrupt request output is the flag gated by the enable. The time counters and the interrupt pin driver are outside this unit.

Top module: `alm_cal_match`

## Requirements
- R1: After reset the four alarm bytes read 0x80 (field disabled) and the control byte reads 0x00. The flag and the interrupt request are low.
- R2: The register addresses are 0 minute, 1 hour, 2 day, 3 weekday and 4 control. Each alarm byte keeps bit 7 (disable) and its value bits: minute 6:0, hour 5:0, day 5:0, weekday 2:0. All other bits read 0.
- R3: The time input `time_now` packs minute at 7:0, hour at 15:8, day at 23:16 and weekday at 31:24. On the cycle where `time_tick` is 1 and every enabled field equals its masked time byte, the flag is set. The flag is visible on the cycle after that tick.
- R4: A field whose bit 7 is 1 takes no part in the match. A field whose bit 7 is 0 must agree for the match to hold.
- R5: The hour comparison covers bits 5:0. In 12-hour mode this includes the AM/PM bit (bit 5), so 05 AM does not match an alarm for 05 PM.
- R6: Once set, the flag stays set across later ticks, whether they match or not, until software clears it.
- R7: The flag is set only when a tick matches and the previous tick did not. A continuing match does not set it again after a clear.
- R8: A write to address 4 loads the interrupt enable from bit 1 and ANDs the flag with bit 3. Writing 0 clears the flag and writing 1 leaves it unchanged. A match edge in the same cycle as a clearing write wins, so the flag ends up set.
- R9: `alarm_irq` is 1 exactly when the flag is 1 and the interrupt enable (control bit 1) is 1.
- R10: With all four fields disabled, no tick ever sets the flag.
- R11: Changes on `time_now` while `time_tick` is 0 have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| time_now | input | 32 | Current BCD time: {weekday, day, hour, minute} |
| time_tick | input | 1 | One-cycle strobe: the time counters hold a new value |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The assertions assume that `time_tick` is a single-cycle pulse and that `time_now` is stable and valid whenever the strobe is high. They also assume that register writes are single-cycle strobes synchronous to `clk`. The stimulus changes every input one time unit after a rising edge and holds it for a full cycle. It raises the strobe only together with a fully formed time value. Between strobes it moves `time_now` only in the test that shows such changes are ignored. The outputs are read at the falling edge, after the combinational read path has settled.

// File: rtl/alm_pkg.sv
package alm_pkg;

   localparam int unsigned DIS_BIT   = 7;
   localparam int unsigned AIE_BIT   = 1;
   localparam int unsigned FLAG_BIT  = 3;
   localparam int unsigned CTRL_SLOT = 4;

   typedef enum logic [2:0] {
      SLOT_MIN  = 3'd0,
      SLOT_HOUR = 3'd1,
      SLOT_DAY  = 3'd2,
      SLOT_WDAY = 3'd3,
      SLOT_CTRL = 3'd4
   } slot_e;

   // value bits compared for each alarm field
   function automatic logic [7:0] field_mask(input int idx);
      case (idx)
         0:       return 8'h7F;
         1:       return 8'h3F;
         2:       return 8'h3F;
         default: return 8'h07;
      endcase
   endfunction

endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
   parameter int unsigned DATA_W  = 8,
   parameter logic [DATA_W-1:0] MASK = '1,
   parameter int unsigned DIS_BIT = DATA_W-1
) (
   input  logic [DATA_W-1:0] alarm_byte,
   input  logic [DATA_W-1:0] time_byte,
   output logic              field_en,
   output logic              field_hit
);

   if (DIS_BIT >= DATA_W) begin : g_bad_dis
      $error("alm_field_cmp: disable bit outside the byte");
   end
   if (MASK[DIS_BIT]) begin : g_bad_mask
      $error("alm_field_cmp: value mask overlaps the disable bit");
   end

   assign field_en  = ~alarm_byte[DIS_BIT];
   assign field_hit = ((alarm_byte ^ time_byte) & MASK) == '0;

endmodule

// File: rtl/alm_regs.sv
module alm_regs #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned N_FIELDS  = 4,
   parameter int unsigned CTRL_SLOT = 4,
   parameter int unsigned AIE_BIT   = 1,
   parameter int unsigned DIS_BIT   = 7
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             reg_we,
   input  logic [ADDR_W-1:0]                reg_addr,
   input  logic [DATA_W-1:0]                reg_wdata,
   output logic [N_FIELDS-1:0][DATA_W-1:0]  alarm_q,
   output logic                             aie_q,
   output logic                             ctrl_wr
);

   localparam logic [DATA_W-1:0] RST_ALARM = DATA_W'(1) << DIS_BIT;

   if (CTRL_SLOT < N_FIELDS) begin : g_bad_slot
      $error("alm_regs: control slot collides with an alarm slot");
   end
   if (CTRL_SLOT >= (1 << ADDR_W)) begin : g_bad_addr
      $error("alm_regs: control slot not addressable");
   end

   assign ctrl_wr = reg_we && (reg_addr == ADDR_W'(CTRL_SLOT));

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_slot
      localparam logic [DATA_W-1:0] KEEP =
         DATA_W'(alm_pkg::field_mask(i)) | RST_ALARM;
      logic hit_wr;
      assign hit_wr = reg_we && (reg_addr == ADDR_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       alarm_q[i] <= RST_ALARM;
         else if (hit_wr)  alarm_q[i] <= reg_wdata & KEEP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        aie_q <= 1'b0;
      else if (ctrl_wr)  aie_q <= reg_wdata[AIE_BIT];
   end

endmodule

// File: rtl/alm_flag.sv
module alm_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic time_tick,
   input  logic match_now,
   input  logic ctrl_wr,
   input  logic flag_wbit,
   output logic flag_q,
   output logic match_q
);

   logic set_evt;
   logic clr_req;

   assign set_evt = time_tick && match_now && !match_q;
   assign clr_req = ctrl_wr && !flag_wbit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          match_q <= 1'b0;
      else if (time_tick)  match_q <= match_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (set_evt)  flag_q <= 1'b1;
      else if (clr_req)  flag_q <= 1'b0;
   end

   // R6
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr_req |=> flag_q);

   // R8
   no_self_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q && !set_evt |=> !flag_q);

   // R3
   set_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(time_tick) && $past(match_now));

   // R7
   edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      time_tick && match_q && !clr_req |=> flag_q == $past(flag_q));

endmodule

// File: rtl/alm_cal_match.sv
module alm_cal_match #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned N_FIELDS  = 4,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   input  logic [N_FIELDS*DATA_W-1:0] time_now,
   input  logic                       time_tick,
   output logic                       alarm_flag,
   output logic                       alarm_irq
);

   localparam int unsigned CTRL_SLOT = alm_pkg::CTRL_SLOT;
   localparam int unsigned AIE_BIT   = alm_pkg::AIE_BIT;
   localparam int unsigned FLAG_BIT  = alm_pkg::FLAG_BIT;
   localparam int unsigned DIS_BIT   = alm_pkg::DIS_BIT;

   if (DATA_W != 8) begin : g_bad_w
      $error("alm_cal_match: BCD fields need an 8-bit data path");
   end
   if (N_FIELDS != 4) begin : g_bad_n
      $error("alm_cal_match: four alarm fields expected");
   end

   logic [N_FIELDS-1:0][DATA_W-1:0] alarm_q;
   logic                            aie_q;
   logic                            ctrl_wr;
   logic [N_FIELDS-1:0]             f_en;
   logic [N_FIELDS-1:0]             f_hit;
   logic                            match_now;
   logic                            match_q;
   logic                            flag_q;

   alm_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_FIELDS(N_FIELDS),
      .CTRL_SLOT(CTRL_SLOT), .AIE_BIT(AIE_BIT), .DIS_BIT(DIS_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .alarm_q(alarm_q), .aie_q(aie_q),
      .ctrl_wr(ctrl_wr)
   );

   for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
      alm_field_cmp #(
         .DATA_W(DATA_W),
         .MASK(DATA_W'(alm_pkg::field_mask(i))),
         .DIS_BIT(DIS_BIT)
      ) u_cmp (
         .alarm_byte(alarm_q[i]),
         .time_byte(time_now[i*DATA_W +: DATA_W]),
         .field_en(f_en[i]),
         .field_hit(f_hit[i])
      );
   end

   assign match_now = (|f_en) && (&(f_hit | ~f_en));

   alm_flag u_flag (
      .clk(clk), .rst_n(rst_n), .time_tick(time_tick),
      .match_now(match_now), .ctrl_wr(ctrl_wr),
      .flag_wbit(reg_wdata[FLAG_BIT]),
      .flag_q(flag_q), .match_q(match_q)
   );

   assign alarm_flag = flag_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= flag_q && aie_q;
      end
      assign alarm_irq = irq_q;
   end else begin : g_irq_comb
      assign alarm_irq = flag_q && aie_q;
      // R9
      irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         alarm_irq |-> aie_q && alarm_flag);
   end

   always_comb begin
      reg_rdata = '0;
      for (int k = 0; k < N_FIELDS; k++) begin
         if (reg_addr == ADDR_W'(k)) reg_rdata = alarm_q[k];
      end
      if (reg_addr == ADDR_W'(CTRL_SLOT)) begin
         reg_rdata[AIE_BIT]  = aie_q;
         reg_rdata[FLAG_BIT] = flag_q;
      end
   end

   // R10
   all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (f_en == '0) && time_tick |=> !match_q);

   // R11
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !time_tick && !ctrl_wr |=> $stable(flag_q));

endmodule

// File: tb/sim_alm_cal_match.sv
module sim_alm_cal_match;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [31:0] time_now = '0;
   logic        time_tick = 1'b0;
   logic        alarm_flag;
   logic        alarm_irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      int         kind;   // 0 flag, 1 irq, 2 read data
      logic [7:0] exp;
      string      req;
   } item_t;

   item_t sb[$];
   item_t it;

   always #(CLK_PERIOD/2) clk = ~clk;

   alm_cal_match u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_now(time_now),
      .time_tick(time_tick), .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
   );

   // monitor: pops expectations and compares at the falling edge
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         logic [7:0] act;
         it = sb.pop_front();
         case (it.kind)
            0:       act = {7'd0, alarm_flag};
            1:       act = {7'd0, alarm_irq};
            default: act = reg_rdata;
         endcase
         tests++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s kind=%0d actual=%02h expected=%02h",
                     it.req, it.kind, act, it.exp);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input int kind, input logic [7:0] exp, input string req);
      item_t n;
      n.kind = kind; n.exp = exp; n.req = req;
      sb.push_back(n);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      step();
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string req);
      reg_addr = a;
      push(2, e, req);
      step();
   endtask

   task automatic tick(input logic [7:0] mi, input logic [7:0] hr,
                       input logic [7:0] dy, input logic [7:0] wd);
      time_now = {wd, dy, hr, mi};
      time_tick = 1'b1;
      step();
      time_tick = 1'b0;
   endtask

   task automatic flag_chk(input logic e, input string req);
      push(0, {7'd0, e}, req);
      step();
   endtask

   task automatic irq_chk(input logic e, input string req);
      push(1, {7'd0, e}, req);
      step();
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();

      // R1 reset state
      for (int a = 0; a < 4; a++) rd_chk(3'(a), 8'h80, "R1 alarm reset");
      rd_chk(3'd4, 8'h00, "R1 ctrl reset");
      flag_chk(1'b0, "R1 flag reset");
      irq_chk(1'b0, "R1 irq reset");

      // R2 storage masks
      wr(3'd0, 8'hFF); rd_chk(3'd0, 8'hFF, "R2 minute mask");
      wr(3'd1, 8'hFF); rd_chk(3'd1, 8'hBF, "R2 hour mask");
      wr(3'd2, 8'hFF); rd_chk(3'd2, 8'hBF, "R2 day mask");
      wr(3'd3, 8'hFF); rd_chk(3'd3, 8'h87, "R2 weekday mask");

      // minute-only alarm at :30
      wr(3'd0, 8'h30);
      wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80);
      tick(8'h29, 8'h10, 8'h01, 8'h02);
      flag_chk(1'b0, "R3 no match");
      tick(8'h30, 8'h10, 8'h01, 8'h02);
      flag_chk(1'b1, "R3 match sets flag");
      irq_chk(1'b0, "R9 irq masked");
      tick(8'h31, 8'h10, 8'h01, 8'h02);
      flag_chk(1'b1, "R6 sticky over non-match");
      wr(3'd4, 8'h0A);
      flag_chk(1'b1, "R8 write one keeps flag");
      irq_chk(1'b1, "R9 irq enabled");
      wr(3'd4, 8'h02);
      flag_chk(1'b0, "R8 write zero clears");
      irq_chk(1'b0, "R9 irq follows flag");

      // R7 continuing match does not re-fire
      tick(8'h30, 8'h11, 8'h01, 8'h02);
      tick(8'h30, 8'h11, 8'h01, 8'h02);
      wr(3'd4, 8'h02);
      tick(8'h30, 8'h11, 8'h01, 8'h02);
      flag_chk(1'b0, "R7 held match no refire");
      tick(8'h31, 8'h11, 8'h01, 8'h02);
      tick(8'h30, 8'h11, 8'h01, 8'h02);
      flag_chk(1'b1, "R7 new match refires");
      wr(3'd4, 8'h02);

      // R11 time change without strobe
      tick(8'h12, 8'h11, 8'h01, 8'h02);
      time_now = {8'h02, 8'h01, 8'h11, 8'h30};
      step(); step();
      flag_chk(1'b0, "R11 no strobe no flag");

      // R8 writing one to a clear flag does not set it
      wr(3'd4, 8'h0A);
      rd_chk(3'd4, 8'h02, "R8 write one no set");

      // R4 / R5 hour with AM/PM, day ignored, weekday checked
      wr(3'd0, 8'h15); wr(3'd1, 8'h25); wr(3'd2, 8'h80); wr(3'd3, 8'h03);
      tick(8'h15, 8'h05, 8'h07, 8'h03);
      flag_chk(1'b0, "R5 AM does not match PM");
      tick(8'h15, 8'h25, 8'h19, 8'h03);
      flag_chk(1'b1, "R4 disabled day ignored");
      wr(3'd4, 8'h02);
      tick(8'h15, 8'h25, 8'h19, 8'h04);
      tick(8'h16, 8'h25, 8'h19, 8'h04);
      tick(8'h15, 8'h25, 8'h19, 8'h04);
      flag_chk(1'b0, "R4 enabled weekday mismatch");
      tick(8'h15, 8'h25, 8'h02, 8'h03);
      flag_chk(1'b1, "R4 weekday agrees");
      wr(3'd4, 8'h02);

      // R10 everything disabled
      for (int a = 0; a < 4; a++) wr(3'(a), 8'h80);
      tick(8'h00, 8'h00, 8'h01, 8'h00);
      tick(8'h59, 8'h23, 8'h31, 8'h06);
      flag_chk(1'b0, "R10 all disabled");

      // R8 set wins over a simultaneous clear
      wr(3'd0, 8'h10);
      tick(8'h00, 8'h00, 8'h01, 8'h00);
      time_now = {8'h00, 8'h01, 8'h00, 8'h10};
      time_tick = 1'b1;
      reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h02;
      step();
      time_tick = 1'b0; reg_we = 1'b0;
      flag_chk(1'b1, "R8 set beats clear");
      irq_chk(1'b1, "R9 irq on set");

      step();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule